// File: doc/BRIEF.md
# Nested Reset Domain Controller

This block turns a set of reset causes into three nested reset outputs: a system reset, a power reset and a backup-domain reset, all active low. The system reset clears the ordinary logic of the chip. The power reset covers the system reset and also clears the reset-cause flags. The backup-domain reset clears only the battery-backed registers. The block also holds a small register of sticky cause flags. Boot software reads this register to find out why the chip restarted, then clears it.

Supply-loss indications assert their outputs asynchronously, with no clock needed. Every other cause takes effect on a clock edge. An output always releases on a rising clock edge, and only after a fixed stretch of cycles, so a one-cycle request still gives every register a full reset pulse. The external reset pin is asynchronous to the clock, so it passes through a synchronizer chain before it is used.

Top module: `rstdom_top`

## Requirements
- R1: The external pin is active low and passes through a two-flop synchronizer. With the pin sampled low at one rising edge and high at the next, sysRstN stays high after the first and second rising edges and goes low after the third. That same edge sets causeFlags bit 0.
- R2: Each reset output stays asserted for at least 16 cycles after its last request. A request sampled at one edge releases the output on the 16th rising edge after that edge. An asynchronous request releases the output on the 16th rising edge after the request drops. No earlier release is allowed.
- R3: A high wdgTimeout or swSysReq at a rising edge drives sysRstN low after that edge. pwrRstN and bkpRstN stay high.
- R4: A high supplyBad or brownOut drives pwrRstN and sysRstN low at once, with no clock edge. While either input is high, causeFlags reads 5'b01000, meaning only bit 3 (power) is set.
- R5: A high standbyExit at a rising edge asserts pwrRstN and sysRstN. The same edge clears every cause flag and sets bit 4 (standby), together with any other cause seen at that edge.
- R6: Whenever pwrRstN is low, sysRstN is also low.
- R7: A high bkpSwReq at a rising edge drives bkpRstN low after that edge. sysRstN, pwrRstN and causeFlags are not changed.
- R8: A high allSupplyLost drives bkpRstN low at once, with no clock edge. sysRstN, pwrRstN and causeFlags are not changed.
- R9: Each cause sets its own flag bit: bit 0 pin, bit 1 watchdog, bit 2 software, bit 3 power, bit 4 standby. A flag stays set through later system resets until a power reset or a clear.
- R10: A high clearFlags at a rising edge zeroes causeFlags after that edge. A cause seen at the same edge still sets its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock for stretching and release |
| supplyBad | input | 1 | Main supply missing or ramping, asynchronous, active high |
| brownOut | input | 1 | Main supply dipped below threshold, asynchronous, active high |
| allSupplyLost | input | 1 | Main and battery supplies both gone, asynchronous, active high |
| pinRstN | input | 1 | External reset pin, asynchronous, active low |
| wdgTimeout | input | 1 | Watchdog expiry strobe |
| swSysReq | input | 1 | Software system-reset request strobe |
| standbyExit | input | 1 | Wake-from-standby event strobe |
| bkpSwReq | input | 1 | Software backup-domain reset request |
| clearFlags | input | 1 | Software strobe that empties the cause flags |
| sysRstN | output | 1 | System reset, active low |
| pwrRstN | output | 1 | Power reset, active low |
| bkpRstN | output | 1 | Backup-domain reset, active low |
| causeFlags | output | 5 | Sticky reset-cause flags |

## Verification
Several rules are checked by assertions on every clock edge: that power reset implies system reset, the minimum asserted width of each stretcher, the one-edge response to watchdog, software and backup requests, and how the flag register updates on clear, standby and cause strobes. Some behaviour only the bench scenarios can show. These are the exact release cycle of each output, the three-edge pin latency, and the asynchronous assertion between clock edges. They also include the isolation of the backup domain from the other two outputs and from the flags, and whether flags survive across a chain of system resets.

// File: rtl/rstdom_pkg.sv
package rstdom_pkg;
  localparam int DOM_SYS = 0;
  localparam int DOM_PWR = 1;
  localparam int DOM_BKP = 2;
  localparam int DOM_N   = 3;

  localparam int FLAG_W    = 5;
  localparam int FLAG_PIN  = 0;
  localparam int FLAG_WDG  = 1;
  localparam int FLAG_SW   = 2;
  localparam int FLAG_PWR  = 3;
  localparam int FLAG_STBY = 4;

  typedef struct packed {
    logic setPin;
    logic setWdg;
    logic setSw;
    logic setStby;
    logic wipe;
    logic swClear;
  } flagStrobe_t;
endpackage

// File: rtl/rstdom_stretch.sv
module rstdom_stretch #(
  parameter int STRETCH_CYCLES = 16
) (
  input  logic clk,
  input  logic arstHi,
  input  logic req,
  output logic active
);
  localparam int CW = $clog2(STRETCH_CYCLES);

  logic [CW-1:0] holdCnt;
  logic          actQ;

  always_ff @(posedge clk or posedge arstHi) begin
    if (arstHi) begin
      actQ    <= 1'b1;
      holdCnt <= '0;
    end else if (req) begin
      actQ    <= 1'b1;
      holdCnt <= '0;
    end else if (actQ) begin
      if (holdCnt == CW'(STRETCH_CYCLES - 1)) actQ <= 1'b0;
      else holdCnt <= holdCnt + 1'b1;
    end
  end

  assign active = actQ;

  // Independent width monitor: cycles seen asserted in a row.
  logic [CW:0] seenCnt;
  always_ff @(posedge clk or posedge arstHi) begin
    if (arstHi) seenCnt <= '0;
    else if (!actQ) seenCnt <= '0;
    else if (seenCnt != (CW+1)'(STRETCH_CYCLES)) seenCnt <= seenCnt + 1'b1;
  end

  // R2: never released before the full stretch has elapsed
  p_hold_min_r2: assert property (@(posedge clk) disable iff (arstHi)
    $fell(actQ) |-> (seenCnt >= (CW+1)'(STRETCH_CYCLES)));
endmodule

// File: rtl/rstdom_ctrl.sv
module rstdom_ctrl
  import rstdom_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int STRETCH_CYCLES = 16
) (
  input  logic              clk,
  input  logic              pwrArst,
  input  logic              allSupplyLost,
  input  logic              pinRstN,
  input  logic              wdgTimeout,
  input  logic              swSysReq,
  input  logic              standbyExit,
  input  logic              bkpSwReq,
  input  logic              clearFlags,
  output logic [DOM_N-1:0]  domAct,
  output flagStrobe_t       strobes
);
  logic [SYNC_STAGES-1:0] pinShift;
  logic                   pinReq;
  logic [DOM_N-1:0]       domReq;
  logic [DOM_N-1:0]       domArst;

  always_ff @(posedge clk or posedge pwrArst) begin
    if (pwrArst) pinShift <= '1;
    else         pinShift <= {pinShift[SYNC_STAGES-2:0], pinRstN};
  end

  assign pinReq = ~pinShift[SYNC_STAGES-1];

  always_comb begin
    domReq[DOM_SYS]  = pinReq | wdgTimeout | swSysReq | standbyExit;
    domArst[DOM_SYS] = pwrArst;
    domReq[DOM_PWR]  = standbyExit;
    domArst[DOM_PWR] = pwrArst;
    domReq[DOM_BKP]  = bkpSwReq;
    domArst[DOM_BKP] = allSupplyLost;
  end

  for (genvar d = 0; d < DOM_N; d++) begin : g_dom
    rstdom_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
      .clk    (clk),
      .arstHi (domArst[d]),
      .req    (domReq[d]),
      .active (domAct[d])
    );
  end

  always_comb begin
    strobes.setPin  = pinReq;
    strobes.setWdg  = wdgTimeout;
    strobes.setSw   = swSysReq;
    strobes.setStby = standbyExit;
    strobes.wipe    = standbyExit;
    strobes.swClear = clearFlags;
  end

  // R1: a synchronized pin request reaches the system stretcher one edge later
  p_pin_to_sys_r1: assert property (@(posedge clk) disable iff (pwrArst)
    pinReq |=> domAct[DOM_SYS]);
endmodule

// File: rtl/rstdom_flags.sv
module rstdom_flags
  import rstdom_pkg::*;
(
  input  logic              clk,
  input  logic              pwrArst,
  input  flagStrobe_t       strobes,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] flagQ;
  logic [FLAG_W-1:0] flagNext;
  logic [FLAG_W-1:0] causeBits;

  always_comb begin
    causeBits            = '0;
    causeBits[FLAG_PIN]  = strobes.setPin;
    causeBits[FLAG_WDG]  = strobes.setWdg;
    causeBits[FLAG_SW]   = strobes.setSw;
    causeBits[FLAG_STBY] = strobes.setStby;
    flagNext = (strobes.wipe || strobes.swClear) ? causeBits : (flagQ | causeBits);
  end

  always_ff @(posedge clk or posedge pwrArst) begin
    if (pwrArst) begin
      flagQ           <= '0;
      flagQ[FLAG_PWR] <= 1'b1;
    end else begin
      flagQ <= flagNext;
    end
  end

  assign flags = flagQ;

  // R9: a watchdog cause is recorded at the next edge
  p_wdg_flag_r9: assert property (@(posedge clk) disable iff (pwrArst)
    strobes.setWdg |=> flagQ[FLAG_WDG]);

  // R10: a clear with no competing cause empties the register
  p_clear_empty_r10: assert property (@(posedge clk) disable iff (pwrArst)
    (strobes.swClear && !strobes.setPin && !strobes.setWdg && !strobes.setSw && !strobes.setStby)
      |=> (flagQ == '0));

  // R5: standby exit leaves only the standby flag when alone
  p_stby_only_r5: assert property (@(posedge clk) disable iff (pwrArst)
    (strobes.wipe && !strobes.setPin && !strobes.setWdg && !strobes.setSw)
      |=> (flagQ == (FLAG_W'(1) << FLAG_STBY)));
endmodule

// File: rtl/rstdom_top.sv
module rstdom_top
  import rstdom_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int STRETCH_CYCLES = 16
) (
  input  logic              clk,
  input  logic              supplyBad,
  input  logic              brownOut,
  input  logic              allSupplyLost,
  input  logic              pinRstN,
  input  logic              wdgTimeout,
  input  logic              swSysReq,
  input  logic              standbyExit,
  input  logic              bkpSwReq,
  input  logic              clearFlags,
  output logic              sysRstN,
  output logic              pwrRstN,
  output logic              bkpRstN,
  output logic [FLAG_W-1:0] causeFlags
);
  logic             pwrArst;
  logic [DOM_N-1:0] domAct;
  flagStrobe_t      strobes;

  assign pwrArst = supplyBad | brownOut;

  rstdom_ctrl #(.SYNC_STAGES(SYNC_STAGES), .STRETCH_CYCLES(STRETCH_CYCLES)) u_ctrl (
    .clk           (clk),
    .pwrArst       (pwrArst),
    .allSupplyLost (allSupplyLost),
    .pinRstN       (pinRstN),
    .wdgTimeout    (wdgTimeout),
    .swSysReq      (swSysReq),
    .standbyExit   (standbyExit),
    .bkpSwReq      (bkpSwReq),
    .clearFlags    (clearFlags),
    .domAct        (domAct),
    .strobes       (strobes)
  );

  rstdom_flags u_flags (
    .clk     (clk),
    .pwrArst (pwrArst),
    .strobes (strobes),
    .flags   (causeFlags)
  );

  assign sysRstN = ~(domAct[DOM_SYS] | domAct[DOM_PWR]);
  assign pwrRstN = ~domAct[DOM_PWR];
  assign bkpRstN = ~domAct[DOM_BKP];

  // R6: the power domain is nested inside the system domain
  p_pwr_nests_sys_r6: assert property (@(posedge clk) disable iff (pwrArst)
    !pwrRstN |-> !sysRstN);

  // R3: watchdog or software request asserts the system reset one edge later
  p_sys_req_r3: assert property (@(posedge clk) disable iff (pwrArst)
    (wdgTimeout || swSysReq) |=> !sysRstN);

  // R7: backup request asserts the backup reset one edge later
  p_bkp_req_r7: assert property (@(posedge clk) disable iff (allSupplyLost)
    bkpSwReq |=> !bkpRstN);
endmodule

// File: tb/tb_rstdom_top.sv
module tb_rstdom_top;
  logic clk = 1'b0;
  logic supplyBad = 1'b0, brownOut = 1'b0, allSupplyLost = 1'b0;
  logic pinRstN = 1'b1, wdgTimeout = 1'b0, swSysReq = 1'b0;
  logic standbyExit = 1'b0, bkpSwReq = 1'b0, clearFlags = 1'b0;
  logic sysRstN, pwrRstN, bkpRstN;
  logic [4:0] causeFlags;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [4:0] expFlags;

  always #2 clk = ~clk;

  rstdom_top dut (
    .clk(clk), .supplyBad(supplyBad), .brownOut(brownOut), .allSupplyLost(allSupplyLost),
    .pinRstN(pinRstN), .wdgTimeout(wdgTimeout), .swSysReq(swSysReq),
    .standbyExit(standbyExit), .bkpSwReq(bkpSwReq), .clearFlags(clearFlags),
    .sysRstN(sysRstN), .pwrRstN(pwrRstN), .bkpRstN(bkpRstN), .causeFlags(causeFlags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0=sys 1=pwr 2=bkp; counts negedge samples while low, starting now
  task automatic countLow(input int which, output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      logic v;
      v = (which == 0) ? sysRstN : (which == 1) ? pwrRstN : bkpRstN;
      if (v) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic tPowerOn();
    int n;
    #1;
    supplyBad = 1'b1; allSupplyLost = 1'b1;
    #0.5;
    chk("R4 pwr async", pwrRstN, 0);
    chk("R4 sys async", sysRstN, 0);
    chk("R8 bkp async", bkpRstN, 0);
    chk("R4 flags at power on", causeFlags, 5'b01000);
    @(negedge clk); allSupplyLost = 1'b0;
    @(negedge clk); countLow(2, n);
    chk("R8 bkp release count", n, 15);
    chk("R8 pwr still held", pwrRstN, 0);
    @(negedge clk); supplyBad = 1'b0;
    @(negedge clk); countLow(1, n);
    chk("R4 pwr release count", n, 15);
    chk("R6 sys released with pwr", sysRstN, 1);
    expFlags = 5'b01000;
  endtask

  task automatic tPin();
    int n;
    @(negedge clk); pinRstN = 1'b0;
    @(negedge clk); pinRstN = 1'b1;
    chk("R1 sys high after 1st edge", sysRstN, 1);
    @(negedge clk);
    chk("R1 sys high after 2nd edge", sysRstN, 1);
    @(negedge clk);
    chk("R1 sys low after 3rd edge", sysRstN, 0);
    expFlags |= 5'b00001;
    chk("R1 pin flag", causeFlags, expFlags);
    countLow(0, n);
    chk("R2 pin stretch", n, 16);
  endtask

  task automatic tWdgSw();
    int n;
    @(negedge clk); wdgTimeout = 1'b1;
    @(negedge clk); wdgTimeout = 1'b0;
    chk("R3 wdg sys low", sysRstN, 0);
    chk("R3 wdg pwr high", pwrRstN, 1);
    chk("R3 wdg bkp high", bkpRstN, 1);
    expFlags |= 5'b00010;
    chk("R9 wdg flag", causeFlags, expFlags);
    countLow(0, n);
    chk("R2 wdg stretch", n, 16);
    @(negedge clk); swSysReq = 1'b1;
    @(negedge clk); swSysReq = 1'b0;
    chk("R3 sw sys low", sysRstN, 0);
    expFlags |= 5'b00100;
    chk("R9 flags sticky across system resets", causeFlags, expFlags);
    countLow(0, n);
    chk("R2 sw stretch", n, 16);
  endtask

  task automatic tStandby();
    int n;
    @(negedge clk); standbyExit = 1'b1;
    @(negedge clk); standbyExit = 1'b0;
    chk("R5 stby pwr low", pwrRstN, 0);
    chk("R5 stby sys low", sysRstN, 0);
    chk("R5 stby flags wiped", causeFlags, 5'b10000);
    chk("R5 bkp untouched", bkpRstN, 1);
    countLow(1, n);
    chk("R2 stby stretch", n, 16);
    chk("R6 sys released with pwr", sysRstN, 1);
    expFlags = 5'b10000;
  endtask

  task automatic tBrownOut();
    int n;
    @(negedge clk); brownOut = 1'b1;
    #0.5;
    chk("R4 brownout pwr async", pwrRstN, 0);
    chk("R4 brownout sys async", sysRstN, 0);
    chk("R4 brownout flags", causeFlags, 5'b01000);
    @(negedge clk); brownOut = 1'b0;
    @(negedge clk); countLow(1, n);
    chk("R4 brownout release count", n, 15);
    expFlags = 5'b01000;
  endtask

  task automatic tBackupSw();
    int n;
    int bad;
    bad = 0;
    n = 0;
    @(negedge clk); bkpSwReq = 1'b1;
    @(negedge clk); bkpSwReq = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (!sysRstN || !pwrRstN) bad++;
      if (bkpRstN) break;
      n++;
      @(negedge clk);
    end
    chk("R7 bkp stretch", n, 16);
    chk("R7 sys and pwr untouched", bad, 0);
    chk("R7 flags untouched", causeFlags, expFlags);
  endtask

  task automatic tSupplyLost();
    int n;
    @(negedge clk); allSupplyLost = 1'b1;
    #0.5;
    chk("R8 bkp async", bkpRstN, 0);
    chk("R8 sys untouched", sysRstN, 1);
    chk("R8 pwr untouched", pwrRstN, 1);
    @(negedge clk); allSupplyLost = 1'b0;
    @(negedge clk); countLow(2, n);
    chk("R8 release count", n, 15);
    chk("R8 flags untouched", causeFlags, expFlags);
  endtask

  task automatic tClear();
    int n;
    @(negedge clk); clearFlags = 1'b1;
    @(negedge clk); clearFlags = 1'b0;
    chk("R10 clear empties", causeFlags, 5'b00000);
    chk("R10 no reset from clear", sysRstN, 1);
    @(negedge clk); clearFlags = 1'b1; swSysReq = 1'b1;
    @(negedge clk); clearFlags = 1'b0; swSysReq = 1'b0;
    chk("R10 cause wins over clear", causeFlags, 5'b00100);
    countLow(0, n);
    chk("R2 sw stretch after clear", n, 16);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tPowerOn();
    tPin();
    tWdgSw();
    tStandby();
    tBrownOut();
    tBackupSw();
    tSupplyLost();
    tClear();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule